// File: doc/BRIEF.md
# DSP Command Sequencer

This block is the host-side controller for a byte-wide sound DSP port. A client hands it one request at a time: a reset-and-detect, a version query, a time-constant write, a halt, a resume, or the start of a block transfer in low-speed or high-speed form. The block expands the request into the byte sequence the DSP expects. It moves each byte across the port by polling a flag with a bounded number of tries, and finishes with a one-cycle completion pulse that carries a result code.

Requests use a valid/ready handshake. `req_ready` is high only while the sequencer is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high, and its fields are sampled only on that edge. While `req_ready` is low the client holds its request and waits. There is no queueing: one request is in flight at a time. The port side is plain. The DSP raises `wr_busy` while it cannot take a byte and `rd_ready` while a byte waits for it. The controller pulses `wr_strobe` or `rd_strobe` in the cycle it moves a byte.

A high-speed transfer leaves the channel locked. In that state a halt is carried out as a full reset instead of a halt byte. The lock clears on a completion interrupt (`irq_in`) or on a finished reset. Each interrupt is acknowledged with a one-cycle `stat_ack` pulse, which stands for the read of the read-status port.

Top module: `dsp_cmd_seq`

## Requirements
- R1: `req_ready` is high exactly when no request is in flight. Every accepted request produces exactly one one-cycle `done` pulse, and `req_ready` is low during that pulse. An op code outside 0..5 finishes in the cycle after acceptance with result code 5 and touches no port pin. Op codes: 0 reset, 1 version, 2 rate, 3 halt, 4 continue, 5 transfer.
- R2: A byte write samples `wr_busy` once per cycle and pulses `wr_strobe` only in a cycle where `wr_busy` is low. If `wr_busy` is high on POLL_MAX (default 100) consecutive samples, the request is abandoned without that byte, `wr_err_cnt` rises by one, and the code is 1 (a transfer instead follows R9).
- R3: A byte read samples `rd_ready` once per cycle and pulses `rd_strobe` only when it is high. If it stays low for POLL_MAX samples, the code is 2 (4 during a recovery reset) and `rd_err_cnt` rises by one.
- R4: A reset holds `dsp_rst` high for at least RST_US and at most RST_US+1 microseconds, timed by a tick derived from CLK_HZ. It then reads one byte. The code is 0 if that byte equals MAGIC (default 8'hAA) and 3 otherwise. No byte is written.
- R5: A version query writes VER_OP and reads two bytes. `result` is {first byte, second byte}, so the major number is in the upper half.
- R6: A rate request writes TC_OP, then `req_arg[7:0]`.
- R7: A low-speed transfer (`req_hs`=0) writes LSI_OP when `req_dir`=1 (input) or LSO_OP when `req_dir`=0, then (`req_arg`-1) mod 65536, low byte first. `locked` does not change.
- R8: A high-speed transfer writes BLK_OP, then (`req_arg`-1) low byte and high byte, then HSI_OP for input or HSO_OP for output. On success `locked` rises in the same cycle as `done`, with code 0.
- R9: If any write of a transfer times out, the block runs the full reset of R4. It then reports code 4, and `locked` stays low.
- R10: A halt with `locked` high runs the R4 reset, writes nothing, and ends with `locked` low. A halt with `locked` low writes only HALT_OP. A continue request writes only CONT_OP.
- R11: A high `irq_in` makes `locked` low and `stat_ack` high in the next cycle. `stat_ack` is high for one cycle per cycle of `irq_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_op | input | 3 | Request kind (0 reset, 1 version, 2 rate, 3 halt, 4 continue, 5 transfer) |
| req_arg | input | 16 | Byte count for a transfer; time constant in bits 7:0 for rate |
| req_dir | input | 1 | Transfer direction, 1 = input from DSP |
| req_hs | input | 1 | Transfer uses high-speed mode |
| done | output | 1 | One-cycle completion pulse |
| err_code | output | 3 | Result code, valid with done (0 ok, 1 write timeout, 2 read timeout, 3 not detected, 4 I/O error, 5 bad op) |
| result | output | 16 | Version word, valid with done after a version query |
| locked | output | 1 | High-speed transfer in progress |
| irq_in | input | 1 | Completion interrupt from the DSP |
| stat_ack | output | 1 | Read-status access acknowledging an interrupt |
| dsp_rst | output | 1 | Reset line to the DSP |
| wr_busy | input | 1 | DSP cannot accept a byte |
| wr_strobe | output | 1 | Byte written this cycle |
| wr_data | output | 8 | Byte being written |
| rd_ready | input | 1 | DSP has a byte to read |
| rd_strobe | output | 1 | Byte read this cycle |
| rd_data | input | 8 | Byte from the DSP |
| wr_err_cnt | output | 16 | Count of write timeouts |
| rd_err_cnt | output | 16 | Count of read timeouts |

## Verification
The bench aims at the poll bound from both sides. With `wr_busy` held for exactly 99 samples the write must still go through, and with 100 it must fail. An off-by-one retry counter turns one of these into the wrong outcome. A port that never frees up in the middle of a transfer must lead to a reset pulse and an I/O code. A design that reported a plain write timeout, or left `locked` set, would be caught there. A halt issued while locked must show a reset and no halt byte. The reset width is measured against the microsecond window, and the two version bytes are checked in the order they were read. Randomized transfers with random count and busy spans expose byte-order errors and count-minus-one errors.

// File: rtl/dsp_seq_pkg.sv
package dsp_seq_pkg;
  typedef enum logic [2:0] {
    OP_RESET   = 3'd0,
    OP_VERSION = 3'd1,
    OP_RATE    = 3'd2,
    OP_HALT    = 3'd3,
    OP_CONT    = 3'd4,
    OP_XFER    = 3'd5
  } op_e;

  typedef enum logic [2:0] {
    E_OK    = 3'd0,
    E_WR_TO = 3'd1,
    E_RD_TO = 3'd2,
    E_NODET = 3'd3,
    E_IO    = 3'd4,
    E_BADOP = 3'd5
  } err_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RHOLD,
    S_RREAD,
    S_WRITE,
    S_READ,
    S_DONE
  } st_e;

  localparam int SLOTS = 4;
  localparam int AW    = 16;
endpackage

// File: rtl/dsp_us_tick.sv
module dsp_us_tick #(
  parameter int CLK_HZ  = 125_000_000,
  parameter int TICK_HZ = 1_000_000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int DIV = (CLK_HZ / TICK_HZ < 2) ? 2 : CLK_HZ / TICK_HZ;
  localparam int CW  = $clog2(DIV);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else if (cnt == CW'(DIV - 1)) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  assign tick = (cnt == CW'(DIV - 1));
endmodule

// File: rtl/dsp_byte_poll.sv
module dsp_byte_poll #(
  parameter int POLL_MAX = 100,
  parameter int DW       = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go_wr,
  input  logic          go_rd,
  input  logic [DW-1:0] wbyte,
  output logic [DW-1:0] rbyte,
  output logic          ok,
  output logic          tmo,
  input  logic          wr_busy,
  output logic          wr_strobe,
  output logic [DW-1:0] wr_data,
  input  logic          rd_ready,
  output logic          rd_strobe,
  input  logic [DW-1:0] rd_data
);
  localparam int CW = $clog2(POLL_MAX + 1);

  logic [CW-1:0] tries;
  logic          last, rd_sel, miss;

  always_comb begin
    rd_sel    = go_rd && !go_wr;
    last      = (tries == CW'(POLL_MAX - 1));
    wr_strobe = go_wr && !wr_busy;
    rd_strobe = rd_sel && rd_ready;
    ok        = wr_strobe || rd_strobe;
    miss      = (go_wr && wr_busy) || (rd_sel && !rd_ready);
    tmo       = miss && last;
    wr_data   = wbyte;
    rbyte     = rd_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) tries <= '0;
    else if (!(go_wr || go_rd) || ok || tmo) tries <= '0;
    else tries <= tries + 1'b1;
  end
endmodule

// File: rtl/dsp_seq_ctl.sv
module dsp_seq_ctl
  import dsp_seq_pkg::*;
#(
  parameter int         RST_US  = 3,
  parameter int         CNT_W   = 16,
  parameter logic [7:0] MAGIC   = 8'hAA,
  parameter logic [7:0] VER_OP  = 8'hE1,
  parameter logic [7:0] TC_OP   = 8'h40,
  parameter logic [7:0] LSO_OP  = 8'h14,
  parameter logic [7:0] LSI_OP  = 8'h24,
  parameter logic [7:0] BLK_OP  = 8'h48,
  parameter logic [7:0] HSO_OP  = 8'h91,
  parameter logic [7:0] HSI_OP  = 8'h99,
  parameter logic [7:0] HALT_OP = 8'hD0,
  parameter logic [7:0] CONT_OP = 8'hD4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [2:0]       req_op,
  input  logic [AW-1:0]    req_arg,
  input  logic             req_dir,
  input  logic             req_hs,
  input  logic             irq_in,
  output logic             stat_ack,
  output logic             go_wr,
  output logic             go_rd,
  output logic [7:0]       wbyte,
  input  logic             ok,
  input  logic             tmo,
  input  logic [7:0]       rbyte,
  output logic             dsp_rst,
  output logic             done,
  output logic [2:0]       err_code,
  output logic [AW-1:0]    result,
  output logic             locked,
  output logic [CNT_W-1:0] wr_err_cnt,
  output logic [CNT_W-1:0] rd_err_cnt
);
  localparam int TW = $clog2(RST_US + 1) + 1;
  localparam int IW = $clog2(SLOTS);

  st_e                   state;
  err_e                  err_q;
  logic [SLOTS-1:0][7:0] wq;
  logic [IW:0]           wn;
  logic [IW-1:0]         wi;
  logic [1:0]            rn, ri;
  logic [TW-1:0]         tcnt;
  logic                  is_xfer, hs_pend, fail_io;
  logic [AW-1:0]         cm1;
  logic                  take, last_wr;

  assign cm1       = req_arg - 1'b1;
  assign req_ready = (state == S_IDLE);
  assign take      = req_valid && req_ready;
  assign last_wr   = ({1'b0, wi} == wn - 1'b1);
  assign dsp_rst   = (state == S_RHOLD);
  assign go_wr     = (state == S_WRITE);
  assign go_rd     = (state == S_RREAD) || (state == S_READ);
  assign wbyte     = wq[wi];
  assign done      = (state == S_DONE);
  assign err_code  = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      err_q      <= E_OK;
      wq         <= '0;
      wn         <= '0;
      wi         <= '0;
      rn         <= '0;
      ri         <= '0;
      tcnt       <= '0;
      is_xfer    <= 1'b0;
      hs_pend    <= 1'b0;
      fail_io    <= 1'b0;
      result     <= '0;
      locked     <= 1'b0;
      stat_ack   <= 1'b0;
      wr_err_cnt <= '0;
      rd_err_cnt <= '0;
    end else begin
      stat_ack <= irq_in;
      unique case (state)
        S_IDLE: if (take) begin
          err_q   <= E_OK;
          result  <= '0;
          wi      <= '0;
          ri      <= '0;
          rn      <= '0;
          tcnt    <= '0;
          is_xfer <= 1'b0;
          hs_pend <= 1'b0;
          fail_io <= 1'b0;
          state   <= S_WRITE;
          case (req_op)
            OP_RESET: state <= S_RHOLD;
            OP_VERSION: begin
              wq[0] <= VER_OP;
              wn    <= 1;
              rn    <= 2'd2;
            end
            OP_RATE: begin
              wq[0] <= TC_OP;
              wq[1] <= req_arg[7:0];
              wn    <= 2;
            end
            OP_HALT: begin
              if (locked) state <= S_RHOLD;
              wq[0] <= HALT_OP;
              wn    <= 1;
            end
            OP_CONT: begin
              wq[0] <= CONT_OP;
              wn    <= 1;
            end
            OP_XFER: begin
              is_xfer <= 1'b1;
              hs_pend <= req_hs;
              if (req_hs) begin
                wq[0] <= BLK_OP;
                wq[1] <= cm1[7:0];
                wq[2] <= cm1[15:8];
                wq[3] <= req_dir ? HSI_OP : HSO_OP;
                wn    <= 4;
              end else begin
                wq[0] <= req_dir ? LSI_OP : LSO_OP;
                wq[1] <= cm1[7:0];
                wq[2] <= cm1[15:8];
                wn    <= 3;
              end
            end
            default: begin
              err_q <= E_BADOP;
              state <= S_DONE;
            end
          endcase
        end
        S_RHOLD: if (tick) begin
          if (tcnt == TW'(RST_US)) state <= S_RREAD;
          else tcnt <= tcnt + 1'b1;
        end
        S_RREAD: begin
          if (ok) begin
            locked <= 1'b0;
            if (fail_io) err_q <= E_IO;
            else if (rbyte != MAGIC) err_q <= E_NODET;
            state <= S_DONE;
          end else if (tmo) begin
            locked     <= 1'b0;
            rd_err_cnt <= rd_err_cnt + 1'b1;
            err_q      <= fail_io ? E_IO : E_RD_TO;
            state      <= S_DONE;
          end
        end
        S_WRITE: begin
          if (ok) begin
            if (last_wr) begin
              if (rn != 2'd0) state <= S_READ;
              else begin
                state <= S_DONE;
                if (hs_pend) locked <= 1'b1;
              end
            end else wi <= wi + 1'b1;
          end else if (tmo) begin
            wr_err_cnt <= wr_err_cnt + 1'b1;
            if (is_xfer) begin
              fail_io <= 1'b1;
              tcnt    <= '0;
              state   <= S_RHOLD;
            end else begin
              err_q <= E_WR_TO;
              state <= S_DONE;
            end
          end
        end
        S_READ: begin
          if (ok) begin
            result <= {result[7:0], rbyte};
            if (ri == rn - 1'b1) state <= S_DONE;
            else ri <= ri + 1'b1;
          end else if (tmo) begin
            rd_err_cnt <= rd_err_cnt + 1'b1;
            err_q      <= E_RD_TO;
            result     <= '0;
            state      <= S_DONE;
          end
        end
        S_DONE: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
      if (irq_in) locked <= 1'b0;
    end
  end
endmodule

// File: rtl/dsp_cmd_seq.sv
module dsp_cmd_seq #(
  parameter int         CLK_HZ   = 125_000_000,
  parameter int         POLL_MAX = 100,
  parameter int         RST_US   = 3,
  parameter int         CNT_W    = 16,
  parameter logic [7:0] MAGIC    = 8'hAA,
  parameter logic [7:0] VER_OP   = 8'hE1,
  parameter logic [7:0] TC_OP    = 8'h40,
  parameter logic [7:0] LSO_OP   = 8'h14,
  parameter logic [7:0] LSI_OP   = 8'h24,
  parameter logic [7:0] BLK_OP   = 8'h48,
  parameter logic [7:0] HSO_OP   = 8'h91,
  parameter logic [7:0] HSI_OP   = 8'h99,
  parameter logic [7:0] HALT_OP  = 8'hD0,
  parameter logic [7:0] CONT_OP  = 8'hD4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [2:0]       req_op,
  input  logic [15:0]      req_arg,
  input  logic             req_dir,
  input  logic             req_hs,
  output logic             done,
  output logic [2:0]       err_code,
  output logic [15:0]      result,
  output logic             locked,
  input  logic             irq_in,
  output logic             stat_ack,
  output logic             dsp_rst,
  input  logic             wr_busy,
  output logic             wr_strobe,
  output logic [7:0]       wr_data,
  input  logic             rd_ready,
  output logic             rd_strobe,
  input  logic [7:0]       rd_data,
  output logic [CNT_W-1:0] wr_err_cnt,
  output logic [CNT_W-1:0] rd_err_cnt
);
  logic       tick, go_wr, go_rd, ok, tmo;
  logic [7:0] wbyte, rbyte;

  dsp_us_tick #(.CLK_HZ(CLK_HZ), .TICK_HZ(1_000_000)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  dsp_byte_poll #(.POLL_MAX(POLL_MAX), .DW(8)) u_poll (
    .clk(clk), .rst_n(rst_n), .go_wr(go_wr), .go_rd(go_rd),
    .wbyte(wbyte), .rbyte(rbyte), .ok(ok), .tmo(tmo),
    .wr_busy(wr_busy), .wr_strobe(wr_strobe), .wr_data(wr_data),
    .rd_ready(rd_ready), .rd_strobe(rd_strobe), .rd_data(rd_data)
  );

  dsp_seq_ctl #(
    .RST_US(RST_US), .CNT_W(CNT_W), .MAGIC(MAGIC), .VER_OP(VER_OP),
    .TC_OP(TC_OP), .LSO_OP(LSO_OP), .LSI_OP(LSI_OP), .BLK_OP(BLK_OP),
    .HSO_OP(HSO_OP), .HSI_OP(HSI_OP), .HALT_OP(HALT_OP), .CONT_OP(CONT_OP)
  ) u_ctl (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_arg(req_arg), .req_dir(req_dir), .req_hs(req_hs),
    .irq_in(irq_in), .stat_ack(stat_ack),
    .go_wr(go_wr), .go_rd(go_rd), .wbyte(wbyte), .ok(ok), .tmo(tmo),
    .rbyte(rbyte), .dsp_rst(dsp_rst), .done(done), .err_code(err_code),
    .result(result), .locked(locked),
    .wr_err_cnt(wr_err_cnt), .rd_err_cnt(rd_err_cnt)
  );
endmodule

// File: rtl/dsp_cmd_seq_chk.sv
module dsp_cmd_seq_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic             done,
  input logic [2:0]       err_code,
  input logic             locked,
  input logic             irq_in,
  input logic             stat_ack,
  input logic             dsp_rst,
  input logic             wr_busy,
  input logic             wr_strobe,
  input logic             rd_ready,
  input logic             rd_strobe,
  input logic [CNT_W-1:0] wr_err_cnt,
  input logic [CNT_W-1:0] rd_err_cnt
);
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done) else $error("done held"); // R1
  AST_DONE_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !req_ready) else $error("ready during done"); // R1
  AST_WRITE_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe |-> !wr_busy) else $error("write while busy"); // R2
  AST_WR_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wr_err_cnt) |-> wr_err_cnt == CNT_W'($past(wr_err_cnt) + 1'b1))
    else $error("write error count jump"); // R2
  AST_READ_WHEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe |-> rd_ready) else $error("read while empty"); // R3
  AST_RD_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rd_err_cnt) |-> rd_err_cnt == CNT_W'($past(rd_err_cnt) + 1'b1))
    else $error("read error count jump"); // R3
  AST_QUIET_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    dsp_rst |-> !wr_strobe && !rd_strobe) else $error("port used in reset"); // R4
  AST_LOCK_ON_SUCCESS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> done && err_code == 3'd0) else $error("lock w/o success"); // R8
  AST_IRQ_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    irq_in |=> !locked && stat_ack) else $error("irq not handled"); // R11
endmodule

bind dsp_cmd_seq dsp_cmd_seq_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .done(done),
  .err_code(err_code), .locked(locked), .irq_in(irq_in), .stat_ack(stat_ack),
  .dsp_rst(dsp_rst), .wr_busy(wr_busy), .wr_strobe(wr_strobe),
  .rd_ready(rd_ready), .rd_strobe(rd_strobe),
  .wr_err_cnt(wr_err_cnt), .rd_err_cnt(rd_err_cnt)
);

// File: tb/sim_dsp_cmd_seq.sv
module sim_dsp_cmd_seq;
  localparam logic [7:0] MAGIC = 8'hAA, VER = 8'hE1, TC = 8'h40;
  localparam logic [7:0] LSO = 8'h14, LSI = 8'h24, BLK = 8'h48;
  localparam logic [7:0] HSO = 8'h91, HSI = 8'h99, HALT = 8'hD0, CONT = 8'hD4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_dir = 1'b0, req_hs = 1'b0, irq_in = 1'b0;
  logic [2:0] req_op = '0;
  logic [15:0] req_arg = '0;
  logic req_ready, done, locked, stat_ack, dsp_rst, wr_busy, wr_strobe;
  logic rd_ready, rd_strobe;
  logic [2:0] err_code;
  logic [15:0] result, wr_err_cnt, rd_err_cnt;
  logic [7:0] wr_data, rd_data;

  int total = 0, bad = 0;
  int busy_k = 0;
  logic stuck_busy = 1'b0, rd_stall = 1'b0, bad_magic = 1'b0, ver_armed = 1'b0;
  logic [7:0] maj = 8'h03, mn = 8'h02;

  always #4 clk = ~clk;

  dsp_cmd_seq u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_arg(req_arg), .req_dir(req_dir), .req_hs(req_hs),
    .done(done), .err_code(err_code), .result(result), .locked(locked),
    .irq_in(irq_in), .stat_ack(stat_ack), .dsp_rst(dsp_rst),
    .wr_busy(wr_busy), .wr_strobe(wr_strobe), .wr_data(wr_data),
    .rd_ready(rd_ready), .rd_strobe(rd_strobe), .rd_data(rd_data),
    .wr_err_cnt(wr_err_cnt), .rd_err_cnt(rd_err_cnt)
  );

  // DSP port model
  int bcnt = 0, ln = 0, qn = 0, rl = 0, rst_len = 0, rst_cnt = 0;
  logic [7:0] wlog [8];
  logic [7:0] q [4];
  logic prev_rst = 1'b0;

  assign wr_busy  = stuck_busy || (bcnt != 0);
  assign rd_ready = (qn != 0) && !rd_stall;
  assign rd_data  = q[0];

  always @(posedge clk) begin
    if (!rst_n) begin
      bcnt <= 0; ln <= 0; qn <= 0; rl <= 0; rst_cnt <= 0; prev_rst <= 1'b0;
    end else begin
      bcnt <= wr_strobe ? busy_k : (bcnt != 0 ? bcnt - 1 : 0);
      if (req_valid && req_ready) begin
        ln <= 0; rst_cnt <= 0;
      end else begin
        if (wr_strobe && ln < 8) begin wlog[ln] <= wr_data; ln <= ln + 1; end
        if (prev_rst && !dsp_rst) rst_cnt <= rst_cnt + 1;
      end
      if (dsp_rst) qn <= 0;
      else if (prev_rst) begin q[0] <= bad_magic ? 8'h55 : MAGIC; qn <= 1; end
      else if (wr_strobe && ver_armed && wr_data == VER) begin
        q[qn] <= maj; q[qn+1] <= mn; qn <= qn + 2;
      end else if (rd_strobe) begin
        q[0] <= q[1]; q[1] <= q[2]; q[2] <= q[3]; qn <= qn - 1;
      end
      if (dsp_rst) rl <= rl + 1;
      else if (prev_rst) begin rst_len <= rl; rl <= 0; end
      prev_rst <= dsp_rst;
    end
  end

  task automatic chk(input bit cond, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!cond) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  logic [2:0] g_err;
  logic [15:0] g_res;
  logic g_lock, g_ready;

  task automatic issue(input logic [2:0] op, input logic [15:0] arg,
                       input logic dir, input logic hs);
    int n = 0;
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_arg = arg; req_dir = dir; req_hs = hs;
    @(negedge clk);
    req_valid = 1'b0;
    while (!done && n < 3000) begin @(negedge clk); n++; end
    chk(done, "R1", "done seen", int'(done), 1);
    g_err = err_code; g_res = result; g_lock = locked; g_ready = req_ready;
  endtask

  function automatic logic [7:0] xb(input logic [2:0] op, input logic [15:0] arg,
                                    input logic dir, input logic hs, input int i);
    logic [15:0] c = arg - 16'd1;
    logic [7:0] e [4];
    e[1] = c[7:0]; e[2] = c[15:8]; e[3] = 8'h00;
    case (op)
      3'd1: e[0] = VER;
      3'd2: begin e[0] = TC; e[1] = arg[7:0]; end
      3'd3: e[0] = HALT;
      3'd4: e[0] = CONT;
      default: begin
        e[0] = hs ? BLK : (dir ? LSI : LSO);
        e[3] = dir ? HSI : HSO;
      end
    endcase
    return e[i];
  endfunction

  function automatic int xn(input logic [2:0] op, input logic hs);
    case (op)
      3'd1, 3'd3, 3'd4: return 1;
      3'd2: return 2;
      3'd5: return hs ? 4 : 3;
      default: return 0;
    endcase
  endfunction

  task automatic chk_log(input string req, input logic [2:0] op,
                         input logic [15:0] arg, input logic dir, input logic hs);
    int en = xn(op, hs);
    bit same = (ln == en);
    int at = 0;
    for (int i = 0; i < en && i < ln; i++)
      if (wlog[i] != xb(op, arg, dir, hs, i)) begin same = 0; at = i; end
    chk(same, req, "byte log (len or byte)",
        (ln << 8) | int'(wlog[at]), (en << 8) | int'(xb(op, arg, dir, hs, at)));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    int ew = 0, er = 0;
    void'($urandom(32'h5EED_0042));
    repeat (4) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    chk(req_ready && !locked && !dsp_rst && !done && !wr_strobe, "R1",
        "reset state", {req_ready, locked, dsp_rst, done}, 4'b1000);
    chk(wr_err_cnt == 0 && rd_err_cnt == 0, "R2", "counters at reset",
        wr_err_cnt + rd_err_cnt, 0);

    // R4 reset and detect
    issue(3'd0, 16'h0, 1'b0, 1'b0);
    chk(g_err == 3'd0, "R4", "detect ok code", g_err, 0);
    chk(rst_cnt == 1 && rst_len >= 375 && rst_len <= 500, "R4",
        "reset width cycles", rst_len, 375);
    chk(ln == 0, "R4", "no writes in reset", ln, 0);
    bad_magic = 1'b1;
    issue(3'd0, 16'h0, 1'b0, 1'b0);
    chk(g_err == 3'd3, "R4", "wrong magic code", g_err, 3);
    bad_magic = 1'b0;

    // R1 bad op
    issue(3'd7, 16'h0, 1'b0, 1'b0);
    chk(g_err == 3'd5 && !g_ready, "R1", "bad op code/ready", g_err, 5);
    chk(ln == 0 && rst_cnt == 0, "R1", "bad op touches no pin", ln, 0);

    // R5 version
    maj = 8'h04; mn = 8'h0D; ver_armed = 1'b1;
    issue(3'd1, 16'h0, 1'b0, 1'b0);
    ver_armed = 1'b0;
    chk(g_err == 0 && g_res == 16'h040D, "R5", "version word", g_res, 16'h040D);
    chk_log("R5", 3'd1, 16'h0, 1'b0, 1'b0);

    // R6 rate
    issue(3'd2, 16'h00A6, 1'b0, 1'b0);
    chk_log("R6", 3'd2, 16'h00A6, 1'b0, 1'b0);

    // R7 low-speed, count 1 and count 0 wrap
    issue(3'd5, 16'h0001, 1'b1, 1'b0);
    chk_log("R7", 3'd5, 16'h0001, 1'b1, 1'b0);
    issue(3'd5, 16'h0000, 1'b0, 1'b0);
    chk_log("R7", 3'd5, 16'h0000, 1'b0, 1'b0);
    chk(!g_lock, "R7", "low-speed leaves unlocked", g_lock, 0);

    // R8 high-speed, then R10 halt by reset
    issue(3'd5, 16'h1234, 1'b0, 1'b1);
    chk_log("R8", 3'd5, 16'h1234, 1'b0, 1'b1);
    chk(g_lock && g_err == 0, "R8", "locked after hs", g_lock, 1);
    issue(3'd3, 16'h0, 1'b0, 1'b0);
    chk(ln == 0 && rst_cnt == 1 && !locked && g_err == 0, "R10",
        "locked halt resets", {ln[3:0], rst_cnt[3:0], 3'b0, locked}, 16'h0010);
    issue(3'd3, 16'h0, 1'b0, 1'b0);
    chk_log("R10", 3'd3, 16'h0, 1'b0, 1'b0);
    issue(3'd4, 16'h0, 1'b0, 1'b0);
    chk_log("R10", 3'd4, 16'h0, 1'b0, 1'b0);

    // R11 interrupt
    issue(3'd5, 16'h0100, 1'b1, 1'b1);
    chk(locked, "R8", "locked before irq", locked, 1);
    @(negedge clk); irq_in = 1'b1;
    @(negedge clk); irq_in = 1'b0;
    chk(!locked && stat_ack, "R11", "irq unlock/ack", {locked, stat_ack}, 2'b01);
    @(negedge clk);
    chk(!stat_ack, "R11", "ack one cycle", stat_ack, 0);

    // R2 poll bound: 99 busy samples pass, 100 fail
    busy_k = 99;
    issue(3'd2, 16'h0033, 1'b0, 1'b0);
    chk(g_err == 0 && wr_err_cnt == 0, "R2", "99 busy polls pass", g_err, 0);
    repeat (110) @(negedge clk);
    busy_k = 100;
    issue(3'd2, 16'h0033, 1'b0, 1'b0);
    ew++;
    chk(g_err == 3'd1 && ln == 1 && wlog[0] == TC, "R2", "100 busy polls fail",
        g_err, 1);
    chk(wr_err_cnt == 16'(ew), "R2", "write error count", wr_err_cnt, ew);
    busy_k = 0;
    repeat (110) @(negedge clk);

    // R9 stuck busy during transfer
    stuck_busy = 1'b1;
    issue(3'd5, 16'h0040, 1'b0, 1'b1);
    stuck_busy = 1'b0;
    ew++;
    chk(g_err == 3'd4 && rst_cnt == 1 && !g_lock && ln == 0, "R9",
        "transfer failure recovery", g_err, 4);
    chk(wr_err_cnt == 16'(ew), "R9", "write error count", wr_err_cnt, ew);

    // R3 read timeout
    ver_armed = 1'b1; rd_stall = 1'b1;
    issue(3'd1, 16'h0, 1'b0, 1'b0);
    ver_armed = 1'b0; rd_stall = 1'b0;
    er++;
    chk(g_err == 3'd2 && rd_err_cnt == 16'(er), "R3", "read timeout",
        {g_err, rd_err_cnt[7:0]}, {3'd2, 8'(er)});
    issue(3'd0, 16'h0, 1'b0, 1'b0);
    chk(g_err == 0, "R4", "reset flushes stale bytes", g_err, 0);

    // random mix
    for (int it = 0; it < 24; it++) begin
      int kind = $urandom % 4;
      logic [15:0] a = 16'($urandom);
      logic d = 1'($urandom);
      busy_k = $urandom % 4;
      case (kind)
        0: begin
          maj = 8'($urandom); mn = 8'($urandom); ver_armed = 1'b1;
          issue(3'd1, a, d, 1'b0);
          ver_armed = 1'b0;
          chk(g_res == {maj, mn}, "R5", "random version", g_res, {maj, mn});
          chk_log("R5", 3'd1, a, d, 1'b0);
        end
        1: begin issue(3'd2, a, d, 1'b0); chk_log("R6", 3'd2, a, d, 1'b0); end
        2: begin issue(3'd5, a, d, 1'b0); chk_log("R7", 3'd5, a, d, 1'b0); end
        default: begin
          issue(3'd5, a, d, 1'b1);
          chk_log("R8", 3'd5, a, d, 1'b1);
          chk(g_lock, "R8", "random hs lock", g_lock, 1);
          @(negedge clk); irq_in = 1'b1;
          @(negedge clk); irq_in = 1'b0;
          chk(!locked, "R11", "random unlock", locked, 0);
        end
      endcase
      chk(g_err == 0, "R1", "random op code", g_err, 0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule